// File: doc/BRIEF.md
# Binary-Field Multiplicative Inverter

This block returns the multiplicative inverse of an element of GF(2^M), with elements held in polynomial basis modulo an irreducible polynomial x^M + POLY. It raises the operand to the power 2^M - 2 by an addition chain built from the binary expansion of M-1. The chain scans that exponent from its most significant bit down. Each step first doubles the run length: the current partial power b_k is squared k times and multiplied by itself, which gives b_2k. When the scanned bit is set, the step then adds one: b_2k is squared once and multiplied by the input, which gives b_2k+1. After the last bit, one more squaring of b_(M-1) gives the inverse. The block uses floor(log2(M-1)) + HW(M-1) - 1 field multiplications in total, where HW is the Hamming weight.

The long runs of squarings pass through a combinational squarer that applies two squarings per clock, so each cycle raises the value to the fourth power. When a run has an odd count, its last step uses a single squaring. Multiplication is done by one shared multiplier that consumes D bits of one operand per clock, most significant digit first. An operand enters over a valid/ready input channel and the inverse leaves over a valid/ready output channel. Only one inversion is in flight at a time. in_ready is high only when the block is idle. A result, once presented, is held unchanged until out_ready accepts it.

Top module: `gf2m_inverter`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: For every nonzero input a, the result r satisfies a·r = 1 in GF(2^M). For M = 7 with polynomial x^7 + x + 1, this holds for all 127 nonzero inputs.
- R3: For M = 239 with polynomial x^239 + x^36 + 1, a·r = 1 holds for the inputs 1, x, and random nonzero operands.
- R4: An all-zero input returns an all-zero result with out_zero = 1. Any nonzero input returns out_zero = 0.
- R5: in_ready drops in the cycle after an operand is accepted and stays low until the result has been taken. Any in_valid or in_data activity during that interval has no effect on the result.
- R6: While out_valid = 1 and out_ready = 0, out_data and out_zero hold steady. out_valid falls in the cycle after a handshake.
- R7: Counting the accepting clock edge as edge 1, out_valid becomes visible after exactly 2 + S + Q + N·(ceil(M/D) + 1) edges for a nonzero input. Here S is the number of doubling steps, floor(log2(M-1)). Q is the sum of ceil(k/2) over the doubling run lengths k. N is the multiplication count. A zero input takes 1 edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block idle and able to take an operand |
| in_data | input | M | Operand to invert |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | M | Inverse of the accepted operand |
| out_zero | output | 1 | Set when the accepted operand was zero |

## Verification
The properties assume nothing about when in_valid or out_ready toggle. The handshake rules are checked against any pattern on those inputs. The zero-result property assumes the operand was sampled at acceptance, so in_data may change freely afterwards. The stimulus exercises this by driving a different operand with in_valid high while a computation is busy, and by holding out_ready low for several cycles before consuming a result. All inputs are driven on the falling edge, so every handshake is settled well before the edge that samples it.

// File: rtl/gf2m_inverter_pkg.sv
package gf2m_inverter_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STEP,
    ST_SQR,
    ST_MUL,
    ST_DONE
  } inv_state_e;
endpackage

// File: rtl/gf2m_squarer.sv
module gf2m_squarer #(
  parameter int M = 239,
  parameter logic [M-1:0] POLY = (M'(1) << 36) | M'(1)
) (
  input  logic [M-1:0] v,
  output logic [M-1:0] sq1,
  output logic [M-1:0] sq2
);
  function automatic logic [M-1:0] xt(input logic [M-1:0] x);
    return {x[M-2:0], 1'b0} ^ (x[M-1] ? POLY : '0);
  endfunction

  // Horner form: r = r*x^2 + v_i spreads each bit to even position 2i, reduced on the fly
  function automatic logic [M-1:0] square(input logic [M-1:0] x);
    logic [M-1:0] r;
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = xt(xt(r));
      r[0] = r[0] ^ x[i];
    end
    return r;
  endfunction

  assign sq1 = square(v);
  assign sq2 = square(sq1);
endmodule

// File: rtl/gf2m_digit_mul.sv
module gf2m_digit_mul #(
  parameter int M = 239,
  parameter int D = 16,
  parameter logic [M-1:0] POLY = (M'(1) << 36) | M'(1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic         done,
  output logic [M-1:0] p
);
  localparam int NDIG = (M + D - 1) / D;
  localparam int NPAD = NDIG * D;
  localparam int CW   = $clog2(NDIG + 1);

  function automatic logic [M-1:0] xt(input logic [M-1:0] x);
    return {x[M-2:0], 1'b0} ^ (x[M-1] ? POLY : '0);
  endfunction

  logic [NPAD-1:0] a_q;
  logic [M-1:0]    b_q, c_q, c_nx;
  logic [CW-1:0]   cnt_q;
  logic            busy_q, done_q;
  logic [M-1:0]    bx [D];
  logic [D-1:0]    dig;

  assign bx[0] = b_q;
  for (genvar g = 1; g < D; g++) begin : g_shift
    assign bx[g] = xt(bx[g-1]);
  end

  assign dig = a_q[NPAD-1 -: D];

  always_comb begin
    c_nx = c_q;
    for (int i = 0; i < D; i++) c_nx = xt(c_nx);
    for (int i = 0; i < D; i++) if (dig[i]) c_nx = c_nx ^ bx[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; c_q <= '0;
      cnt_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        a_q    <= NPAD'(a);
        b_q    <= b;
        c_q    <= '0;
        cnt_q  <= CW'(NDIG);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        c_q   <= c_nx;
        a_q   <= a_q << D;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign p    = c_q;
endmodule

// File: rtl/gf2m_inverter.sv
module gf2m_inverter
  import gf2m_inverter_pkg::*;
#(
  parameter int M = 239,
  parameter int D = 16,
  parameter logic [M-1:0] POLY = (M'(1) << 36) | M'(1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [M-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [M-1:0] out_data,
  output logic         out_zero
);
  localparam int TOPB = $clog2(M) - 1;
  localparam int KW   = $clog2(M) + 1;
  localparam int RW   = $clog2(TOPB + 1) + 1;
  localparam logic [KW-1:0] EXPN = KW'(M - 1);

  inv_state_e  st_q;
  logic [M-1:0] a_q, beta_q, t_q, res_q;
  logic [KW-1:0] k_q, left_q;
  logic [RW-1:0] rem_q;
  logic         plus_q, zero_q;

  logic [M-1:0] t_sq1, t_sq2, p_in, p_sq1, p_sq2;
  logic         mul_start, mul_done;
  logic [M-1:0] mul_a, mul_b, mul_p;
  logic         bit_set;

  gf2m_squarer #(.M(M), .POLY(POLY)) u_sq_run (
    .v(t_q), .sq1(t_sq1), .sq2(t_sq2)
  );

  assign p_in = (st_q == ST_MUL) ? mul_p : beta_q;

  gf2m_squarer #(.M(M), .POLY(POLY)) u_sq_one (
    .v(p_in), .sq1(p_sq1), .sq2(p_sq2)
  );

  gf2m_digit_mul #(.M(M), .D(D), .POLY(POLY)) u_mul (
    .clk(clk), .rst_n(rst_n), .start(mul_start),
    .a(mul_a), .b(mul_b), .done(mul_done), .p(mul_p)
  );

  assign bit_set = (rem_q != '0) && EXPN[rem_q - 1'b1];

  always_comb begin
    mul_start = 1'b0;
    mul_a     = t_sq1;
    mul_b     = beta_q;
    if (st_q == ST_SQR && left_q <= KW'(2)) begin
      mul_start = 1'b1;
      mul_a     = (left_q == KW'(2)) ? t_sq2 : t_sq1;
    end else if (st_q == ST_MUL && mul_done && !plus_q && bit_set) begin
      mul_start = 1'b1;
      mul_a     = p_sq1;
      mul_b     = a_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      a_q <= '0; beta_q <= '0; t_q <= '0; res_q <= '0;
      k_q <= '0; left_q <= '0; rem_q <= '0;
      plus_q <= 1'b0; zero_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (in_valid) begin
          a_q    <= in_data;
          beta_q <= in_data;
          k_q    <= KW'(1);
          rem_q  <= RW'(TOPB);
          if (in_data == '0) begin
            res_q  <= '0;
            zero_q <= 1'b1;
            st_q   <= ST_DONE;
          end else begin
            zero_q <= 1'b0;
            st_q   <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (rem_q == '0) begin
            res_q <= p_sq1;
            st_q  <= ST_DONE;
          end else begin
            t_q    <= beta_q;
            left_q <= k_q;
            plus_q <= 1'b0;
            st_q   <= ST_SQR;
          end
        end
        ST_SQR: begin
          if (left_q > KW'(2)) begin
            t_q    <= t_sq2;
            left_q <= left_q - KW'(2);
          end else begin
            st_q <= ST_MUL;
          end
        end
        ST_MUL: if (mul_done) begin
          beta_q <= mul_p;
          if (!plus_q) begin
            k_q <= k_q << 1;
            if (bit_set) begin
              plus_q <= 1'b1;
            end else begin
              rem_q <= rem_q - 1'b1;
              st_q  <= ST_STEP;
            end
          end else begin
            k_q   <= k_q + 1'b1;
            rem_q <= rem_q - 1'b1;
            st_q  <= ST_STEP;
          end
        end
        ST_DONE: if (out_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_DONE);
  assign out_data  = res_q;
  assign out_zero  = zero_q;
endmodule

// File: rtl/gf2m_inverter_chk.sv
module gf2m_inverter_chk #(
  parameter int M = 239
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [M-1:0] out_data,
  input logic         out_zero
);
  assert_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_zero));

  assert_result_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid);

  assert_zero_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_zero |-> out_data == '0);

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
endmodule

bind gf2m_inverter gf2m_inverter_chk #(.M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_zero(out_zero)
);

// File: tb/gf2m_inverter_tb.sv
module gf2m_inverter_tb;
  localparam int MS = 7;
  localparam int DS = 3;
  localparam logic [MS-1:0] PS = 7'b0000011;
  localparam int MB = 239;
  localparam int DB = 16;
  localparam logic [MB-1:0] PB = (MB'(1) << 36) | MB'(1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic iv7 = 0, ir7, ov7, or7 = 0, oz7;
  logic [MS-1:0] id7 = '0, od7;
  logic ivb = 0, irb, ovb, orb = 0, ozb;
  logic [MB-1:0] idb = '0, odb;

  int n_tests = 0, n_fail = 0, cycles = 0;

  gf2m_inverter #(.M(MS), .D(DS), .POLY(PS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(iv7), .in_ready(ir7), .in_data(id7),
    .out_valid(ov7), .out_ready(or7), .out_data(od7), .out_zero(oz7));

  gf2m_inverter #(.M(MB), .D(DB), .POLY(PB)) u_dut_big (
    .clk(clk), .rst_n(rst_n), .in_valid(ivb), .in_ready(irb), .in_data(idb),
    .out_valid(ovb), .out_ready(orb), .out_data(odb), .out_zero(ozb));

  function automatic logic [255:0] gmul(input logic [255:0] a, input logic [255:0] b,
                                        input int m, input logic [255:0] poly);
    logic [255:0] r, mask;
    logic c;
    r = '0;
    mask = (256'd1 << m) - 1;
    for (int i = m - 1; i >= 0; i--) begin
      c = r[m-1];
      r = (r << 1) & mask;
      if (c) r = r ^ poly;
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic int exp_lat(input int m, input int d);
    int e, top, k, ndbl, sq, nmul;
    e = m - 1; top = 0;
    while ((e >> (top + 1)) != 0) top++;
    k = 1; ndbl = 0; sq = 0; nmul = 0;
    for (int bi = top - 1; bi >= 0; bi--) begin
      sq += (k + 1) / 2; ndbl++; nmul++; k = 2 * k;
      if (e[bi]) begin nmul++; k++; end
    end
    return 2 + ndbl + sq + nmul * ((m + d - 1) / d + 1);
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_s(input logic [MS-1:0] a, output logic [MS-1:0] r, output logic z, output int cyc);
    @(negedge clk); iv7 = 1; id7 = a;
    while (!ir7) @(negedge clk);
    @(negedge clk); iv7 = 0; cyc = 1;
    while (!ov7 && cyc < 5000) begin @(negedge clk); cyc++; end
    r = od7; z = oz7;
    or7 = 1; @(negedge clk); or7 = 0;
  endtask

  task automatic run_b(input logic [MB-1:0] a, output logic [MB-1:0] r, output logic z, output int cyc);
    @(negedge clk); ivb = 1; idb = a;
    while (!irb) @(negedge clk);
    @(negedge clk); ivb = 0; cyc = 1;
    while (!ovb && cyc < 5000) begin @(negedge clk); cyc++; end
    r = odb; z = ozb;
    orb = 1; @(negedge clk); orb = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(ir7 && !ov7, "R1 small idle", {ir7, ov7}, 2'b10);
    check(irb && !ovb, "R1 large idle", {irb, ovb}, 2'b10);
  endtask

  task automatic t_small_all();
    logic [MS-1:0] r; logic z; int cyc;
    for (int a = 1; a < 128; a++) begin
      run_s(MS'(a), r, z, cyc);
      check(gmul(256'(a), 256'(r), MS, 256'(PS)) == 256'd1, "R2 a*inv", r, 0);
      check(!z, "R4 nonzero flag", z, 0);
      if (a % 32 == 1) check(cyc == exp_lat(MS, DS), "R7 small latency", cyc, exp_lat(MS, DS));
    end
  endtask

  task automatic t_zero();
    logic [MS-1:0] r; logic [MB-1:0] rb; logic z; int cyc;
    run_s('0, r, z, cyc);
    check(r == '0 && z, "R4 small zero", {r, z}, 1);
    check(cyc == 1, "R7 zero latency", cyc, 1);
    run_b('0, rb, z, cyc);
    check(rb == '0 && z, "R4 large zero", {rb, z}, 1);
  endtask

  task automatic t_big();
    logic [MB-1:0] a, r; logic z; int cyc;
    for (int n = 0; n < 6; n++) begin
      if (n == 0) a = MB'(1);
      else if (n == 1) a = MB'(2);
      else begin
        for (int w = 0; w < 8; w++) a[w*30 +: 29] = 29'($urandom);
        if (a == '0) a = MB'(3);
      end
      run_b(a, r, z, cyc);
      check(gmul(256'(a), 256'(r), MB, 256'(PB)) == 256'd1, "R3 a*inv large", r, 0);
      check(!z, "R4 large nonzero flag", z, 0);
      check(cyc == exp_lat(MB, DB), "R7 large latency", cyc, exp_lat(MB, DB));
    end
  endtask

  task automatic t_busy_ignore();
    logic [MS-1:0] r;
    bit low_ok = 1;
    @(negedge clk); iv7 = 1; id7 = 7'd5;
    while (!ir7) @(negedge clk);
    @(negedge clk); id7 = 7'd9;
    for (int i = 0; i < 6; i++) begin
      if (ir7) low_ok = 0;
      @(negedge clk);
    end
    iv7 = 0;
    while (!ov7) @(negedge clk);
    r = od7;
    check(low_ok, "R5 in_ready low while busy", low_ok, 1);
    check(gmul(256'd5, 256'(r), MS, 256'(PS)) == 256'd1, "R5 late operand ignored", r, 0);
    or7 = 1; @(negedge clk); or7 = 0;
  endtask

  task automatic t_hold();
    logic [MS-1:0] r0; logic z0;
    @(negedge clk); iv7 = 1; id7 = 7'd77;
    while (!ir7) @(negedge clk);
    @(negedge clk); iv7 = 0;
    while (!ov7) @(negedge clk);
    r0 = od7; z0 = oz7;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(ov7 && od7 == r0 && oz7 == z0, "R6 held under back-pressure", od7, r0);
    end
    or7 = 1; @(negedge clk); or7 = 0;
    check(!ov7 && ir7, "R6 released after handshake", {ov7, ir7}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_small_all();
    t_zero();
    t_big();
    t_busy_ignore();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule